// File: doc/BRIEF.md
# NAND Command Queue Sequencer

This block turns a stream of 32-bit command words, written by a host one per cycle, into timed cycles on a raw 8-bit NAND flash bus. Each word encodes one bus micro-operation: a command-latch cycle, an address-latch cycle, a single data byte written or read, a timed pause, or a wait for the flash ready line. Words are held in a small queue and then pass through a two-stage pipeline. The first stage is a fetch register loaded from the queue. The second stage is an execution engine that drives chip enables, latch enables, the write and read strobes and the data bus.

The queue occupancy that the host can read counts only the words still in the queue. A word in the fetch register and a word under execution are not counted, so the occupancy can read zero while two operations are still outstanding. Software that needs every earlier operation finished pushes two zero-length pauses behind its real work. A byte captured by a read operation is held in a buffer output until the next read. The bus cycle length and a timing value are set through a separate configuration register. A command word with its top bit set clears the whole pipeline.

Top module: `nandq_seq`

## Requirements
- R1: After reset the bus is idle (both chip enables high, CLE and ALE low, both strobes high, data bus not driven). The queue level and overflow flag are 0, the read buffer is 0, and the configuration readback is 0x0E5 (cycle field 5, timing field 7).
- R2: Opcode 0x5 in word bits [17:14] makes one command-latch bus cycle. CLE is high and the data bus is driven with word bits [7:0] for exactly L clocks, where L is the configured cycle length. The write strobe is low for the first max(1, floor(L/2)) of those clocks and high for the rest.
- R3: Opcode 0x6 makes one address-latch bus cycle with the same timing as R2, with ALE high instead of CLE.
- R4: Opcode 0x4 drives word bits [7:0] for L clocks with the write strobe pulsed as in R2, and keeps CLE and ALE low.
- R5: Opcode 0x8 keeps the bus undriven and pulses the read strobe low for max(1, floor(L/2)) clocks. It captures the data input on the rising edge of the read strobe into the read-buffer output. The two strobes are never low together.
- R6: Word bits [11:10] (the low two bits of the select field [13:10]) drive the active-low chip enables during a listed operation, so 0xE selects enable 0 and 0xD selects enable 1. Both enables stay high whenever no listed operation is executing.
- R7: Opcode 0xC is a pause of N bus cycles, with N taken from word bits [9:0]. It lasts N*L clocks, or one clock when N is 0. The selected chip enable is held low during the pause, and no strobe moves.
- R8: Opcode 0x1 holds the chip enable and blocks all later words until the ready input is sampled high.
- R9: Any other opcode is consumed in a single clock with no chip-enable, latch, strobe or data-bus activity, and later words still execute.
- R10: Words execute in the order they were written. The queue level appears in status bits [26:22] and excludes the fetch and execute stages, so it reads 0 while one word waits in fetch behind a blocked one.
- R11: A word written while the queue holds DEPTH entries is dropped, and a sticky overflow output is set.
- R12: A write with bit 31 set is not queued. It empties the queue and the fetch stage, aborts the executing operation (all enables go high), and clears the overflow flag. The configuration is kept.
- R13: A configuration write sets L to bits [4:0] plus 1 and stores the timing value from bits [9:5]. Both fields read back in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| cmd_status | output | 32 | Status word, queue level in [26:22] |
| cfg_rdata | output | 32 | Configuration readback |
| rd_byte | output | 8 | Last byte captured by a read operation |
| q_ovf | output | 1 | Sticky queue overflow flag |
| nand_ce_n | output | 2 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Flash ready (high) / busy (low) |

## Verification
Every strobe-bearing opcode is swept over cycle lengths 1 through 8. Counting CLE, ALE, strobe-low and drive clocks for each length separates the odd and even rounding of the strobe width, and also catches an off-by-one in the cycle counter. In the bench the read data changes level as soon as the read strobe rises, so a capture made one edge too late returns the wrong byte. Pause lengths 0 to 4 are swept at a fixed cycle length. Mixed sequences, a blocked ready wait, queue filling past DEPTH and a mid-operation clear test ordering, the in-flight count rule, the drop rule and the abort rule.

// File: rtl/nandq_pkg.sv
package nandq_pkg;
  localparam int unsigned OPC_LSB  = 14;
  localparam int unsigned SEL_LSB  = 10;
  localparam int unsigned LVL_LSB  = 22;
  localparam int unsigned CYC_W    = 5;
  localparam int unsigned ARG_W    = 10;

  localparam logic [3:0] OP_WAITRDY = 4'h1;
  localparam logic [3:0] OP_DWR     = 4'h4;
  localparam logic [3:0] OP_CLE     = 4'h5;
  localparam logic [3:0] OP_ALE     = 4'h6;
  localparam logic [3:0] OP_DRD     = 4'h8;
  localparam logic [3:0] OP_IDLE    = 4'hC;

  localparam logic [CYC_W-1:0] CYC_RST = 5'd5;
  localparam logic [CYC_W-1:0] TIM_RST = 5'd7;

  typedef struct packed {
    logic [3:0]       op;
    logic [1:0]       ce_n;
    logic [ARG_W-1:0] arg;
  } nq_cmd_t;

  function automatic logic op_is_wr(input logic [3:0] op);
    return (op == OP_CLE) || (op == OP_ALE) || (op == OP_DWR);
  endfunction

  function automatic logic op_is_listed(input logic [3:0] op);
    return op_is_wr(op) || (op == OP_DRD) || (op == OP_IDLE) || (op == OP_WAITRDY);
  endfunction
endpackage

// File: rtl/nandq_fifo.sv
module nandq_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          take,
  output logic          fet_vld,
  output logic [W-1:0]  fet_word,
  output logic [LW-1:0] level,
  output logic          ovf
);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, push_ok, pop;

  assign full    = (level == LVL_FULL);
  assign push_ok = push && !full;
  assign pop     = (level != '0) && (!fet_vld || take);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) fet_word <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      fet_vld <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_LAST) ? '0 : wptr + AW'(1);
      if (pop)     rptr <= (rptr == PTR_LAST) ? '0 : rptr + AW'(1);
      case ({push_ok, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
      if (pop)       fet_vld <= 1'b1;
      else if (take) fet_vld <= 1'b0;
      if (push && full) ovf <= 1'b1;
    end
  end

  assert_take_needs_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    take |-> fet_vld);
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    (push && full && !clr) |=> (ovf && level == $past(level) - LW'($past(pop))));
  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0 && !fet_vld && !ovf));
endmodule

// File: rtl/nandq_exec.sv
module nandq_exec
  import nandq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  nq_cmd_t          cmd,
  input  logic [CYC_W-1:0] cyc_m1,
  input  logic             rb_n,
  input  logic [7:0]       dq_i,
  output logic             busy,
  output logic [1:0]       ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  output logic [7:0]       rd_byte
);
  logic [3:0]       op_q;
  logic [CYC_W-1:0] ph;
  logic [ARG_W-1:0] cnt;
  logic [CYC_W:0]   len_w, half_w, lowl_w;
  logic [CYC_W-1:0] low_last;
  logic             k_wr, k_rd, fin, cap;

  always_comb begin
    len_w    = {1'b0, cyc_m1} + (CYC_W+1)'(1);
    half_w   = len_w >> 1;
    lowl_w   = (half_w == '0) ? '0 : half_w - (CYC_W+1)'(1);
    low_last = lowl_w[CYC_W-1:0];
    k_wr     = op_is_wr(op_q);
    k_rd     = (op_q == OP_DRD);
    if (k_wr || k_rd)            fin = (ph == cyc_m1);
    else if (op_q == OP_IDLE)    fin = (cnt == '0) || ((ph == cyc_m1) && (cnt == ARG_W'(1)));
    else if (op_q == OP_WAITRDY) fin = rb_n;
    else                         fin = 1'b1;
    fin = fin && busy;
    cap = busy && k_rd && !re_n && (ph == low_last);
  end

  always_ff @(posedge clk) begin
    if (rst || abort || fin) begin
      busy  <= 1'b0;
      ce_n  <= 2'b11;
      cle   <= 1'b0;
      ale   <= 1'b0;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      dq_oe <= 1'b0;
      ph    <= '0;
      if (rst) begin
        op_q <= '0;
        cnt  <= '0;
        dq_o <= '0;
      end
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        ph    <= '0;
        op_q  <= cmd.op;
        cnt   <= cmd.arg;
        ce_n  <= op_is_listed(cmd.op) ? cmd.ce_n : 2'b11;
        cle   <= (cmd.op == OP_CLE);
        ale   <= (cmd.op == OP_ALE);
        dq_o  <= cmd.arg[7:0];
        dq_oe <= op_is_wr(cmd.op);
        we_n  <= !op_is_wr(cmd.op);
        re_n  <= !(cmd.op == OP_DRD);
      end
    end else begin
      ph <= ph + CYC_W'(1);
      if ((k_wr || k_rd) && (ph == low_last)) begin
        we_n <= 1'b1;
        re_n <= 1'b1;
      end
      if ((op_q == OP_IDLE) && (ph == cyc_m1)) begin
        ph  <= '0;
        cnt <= cnt - ARG_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_byte <= '0;
    else if (cap) rd_byte <= dq_i;
  end

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  assert_capture_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_byte) |-> $rose(re_n));
  assert_latch_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
  assert_strobe_has_ce_R6: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> (ce_n != 2'b11));
  assert_wait_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q == OP_WAITRDY && !rb_n && !abort) |=> busy);
  assert_unlisted_one_clock_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_is_listed(op_q)) |=> !busy);
endmodule

// File: rtl/nandq_seq.sv
module nandq_seq
  import nandq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cmd_status,
  output logic [31:0] cfg_rdata,
  output logic [7:0]  rd_byte,
  output logic        q_ovf,
  output logic [1:0]  nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_n
);
  localparam int unsigned CW = $bits(nq_cmd_t);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [CYC_W-1:0] cyc_q, tim_q;
  logic             clr, push, take, fet_vld, busy;
  nq_cmd_t          in_cmd, fet_cmd;
  logic [CW-1:0]    fet_raw;
  logic [LW-1:0]    level;
  logic             unused_bits;

  assign unused_bits = ^{cmd_wdata[30:18], cmd_wdata[13:12], cfg_wdata[31:10]};

  assign clr  = cmd_we && cmd_wdata[31];
  assign push = cmd_we && !cmd_wdata[31];
  assign in_cmd.op   = cmd_wdata[OPC_LSB +: 4];
  assign in_cmd.ce_n = cmd_wdata[SEL_LSB +: 2];
  assign in_cmd.arg  = cmd_wdata[ARG_W-1:0];
  assign fet_cmd = nq_cmd_t'(fet_raw);
  assign take    = fet_vld && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= CYC_RST;
      tim_q <= TIM_RST;
    end else if (cfg_we) begin
      cyc_q <= cfg_wdata[CYC_W-1:0];
      tim_q <= cfg_wdata[2*CYC_W-1:CYC_W];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[2*CYC_W-1:0] = {tim_q, cyc_q};
    cmd_status = '0;
    cmd_status[LVL_LSB +: LW] = level;
  end

  nandq_fifo #(.DEPTH(DEPTH), .W(CW)) fifo_i (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .push_data(in_cmd),
    .take(take), .fet_vld(fet_vld), .fet_word(fet_raw), .level(level), .ovf(q_ovf)
  );

  nandq_exec exec_i (
    .clk(clk), .rst(rst), .abort(clr), .start(take), .cmd(fet_cmd), .cyc_m1(cyc_q),
    .rb_n(nand_rb_n), .dq_i(nand_dq_i), .busy(busy), .ce_n(nand_ce_n),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .rd_byte(rd_byte)
  );

  assert_abort_releases_ce_R12: assert property (@(posedge clk) disable iff (rst)
    clr |=> (nand_ce_n == 2'b11));
endmodule

// File: tb/nandq_seq_tb.sv
module nandq_seq_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cmd_status, cfg_rdata;
  logic [7:0]  rd_byte, nand_dq_o, nand_dq_i, rd_pat = 8'h00;
  logic        q_ovf, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic        nand_rb_n = 1'b1;
  logic [1:0]  nand_ce_n;

  int errors = 0, checks = 0;
  bit done = 0;
  int n_cle, n_ale, n_we, n_re, n_oe, n_ce0, n_ce1, n_ce, n_wecle, nlog;
  logic [7:0] last_dq;
  logic [9:0] logv [8];
  logic prev_we = 1'b1;

  always #4 clk = ~clk;

  assign nand_dq_i = nand_re_n ? 8'h3C : rd_pat;

  nandq_seq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cmd_status(cmd_status), .cfg_rdata(cfg_rdata),
    .rd_byte(rd_byte), .q_ovf(q_ovf), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb_n(nand_rb_n)
  );

  always @(negedge clk) begin
    if (nand_cle) n_cle++;
    if (nand_ale) n_ale++;
    if (!nand_we_n) begin n_we++; last_dq = nand_dq_o; end
    if (!nand_re_n) n_re++;
    if (nand_dq_oe) n_oe++;
    if (nand_ce_n == 2'b10) n_ce0++;
    if (nand_ce_n == 2'b01) n_ce1++;
    if (nand_ce_n != 2'b11) n_ce++;
    if (!nand_we_n && nand_cle) n_wecle++;
    if (prev_we && !nand_we_n && nlog < 8) begin
      logv[nlog] = {nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd3), nand_dq_o};
      nlog++;
    end
    prev_we = nand_we_n;
  end

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] sel,
                                     input logic [9:0] arg);
    return {14'b0, op, sel, arg};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(posedge clk);
    n_cle = 0; n_ale = 0; n_we = 0; n_re = 0; n_oe = 0;
    n_ce0 = 0; n_ce1 = 0; n_ce = 0; n_wecle = 0; nlog = 0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int hw;
    mon_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(2);
    // R1 reset state
    chk("R1 ce_n", nand_ce_n, 3);
    chk("R1 strobes", {nand_we_n, nand_re_n}, 3);
    chk("R1 latches+oe", {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk("R1 level", cmd_status[26:22], 0);
    chk("R1 ovf", q_ovf, 0);
    chk("R1 rd_byte", rd_byte, 0);
    chk("R1 cfg default", cfg_rdata, 32'h0E5);

    // R2 at default length 6
    mon_clear();
    push(mk(4'h5, 4'hE, 10'h05A));
    settle(30);
    chk("R2 cle clocks L=6", n_cle, 6);
    chk("R2 we low L=6", n_wecle, 3);
    chk("R2 byte", last_dq, 8'h5A);
    chk("R6 ce0 clocks", n_ce0, 6);

    // Sweep cycle length over every strobe opcode
    for (int len = 1; len <= 8; len++) begin
      hw = (len / 2 == 0) ? 1 : len / 2;
      set_cfg(32'((7 << 5) | (len - 1)));
      chk("R13 cfg readback", cfg_rdata, (7 << 5) | (len - 1));
      mon_clear();
      push(mk(4'h5, 4'hE, 10'(len * 17)));
      settle(30);
      chk("R2 cle clocks", n_cle, len);
      chk("R2 we low", n_we, hw);
      chk("R2 we inside cle", n_wecle, hw);
      chk("R2 oe clocks", n_oe, len);
      chk("R2 byte", last_dq, (len * 17) & 255);
      mon_clear();
      push(mk(4'h6, 4'hD, 10'h0A0 + 10'(len)));
      settle(30);
      chk("R3 ale clocks", n_ale, len);
      chk("R3 we low", n_we, hw);
      chk("R6 ce1 clocks", n_ce1, len);
      chk("R6 ce0 unused", n_ce0, 0);
      mon_clear();
      push(mk(4'h4, 4'hE, 10'h0C0 + 10'(len)));
      settle(30);
      chk("R4 oe clocks", n_oe, len);
      chk("R4 we low", n_we, hw);
      chk("R4 no latch", n_cle + n_ale, 0);
      chk("R4 byte", last_dq, 8'hC0 + 8'(len));
      mon_clear();
      rd_pat = 8'h81 + 8'(len * 3);
      push(mk(4'h8, 4'hE, 10'h0));
      settle(30);
      chk("R5 re low", n_re, hw);
      chk("R5 no drive", n_oe + n_we, 0);
      chk("R5 captured", rd_byte, 8'h81 + 8'(len * 3));
    end

    // R13 timing field stored
    set_cfg(32'((19 << 5) | 2));
    chk("R13 cfg timing", cfg_rdata, (19 << 5) | 2);

    // R7 pause lengths at L=3
    for (int n = 0; n <= 4; n++) begin
      mon_clear();
      push(mk(4'hC, 4'hE, 10'(n)));
      settle(30);
      chk("R7 pause clocks", n_ce0, (n == 0) ? 1 : n * 3);
      chk("R7 no strobe", n_we + n_re + n_oe, 0);
    end

    // R9 unlisted opcodes
    mon_clear();
    push(mk(4'h2, 4'hE, 10'h0FF));
    push(mk(4'hF, 4'hD, 10'h0AA));
    push(mk(4'h5, 4'hE, 10'h011));
    settle(30);
    chk("R9 no ce", n_ce, 3);
    chk("R9 no other strobe", n_re + n_ale, 0);
    chk("R9 next runs", n_cle, 3);

    // R10 ordering, L=2
    set_cfg(32'h1);
    mon_clear();
    push(mk(4'h5, 4'hE, 10'h000));
    push(mk(4'h6, 4'hE, 10'h011));
    push(mk(4'h6, 4'hE, 10'h022));
    push(mk(4'h4, 4'hE, 10'h033));
    push(mk(4'h5, 4'hE, 10'h030));
    settle(40);
    chk("R10 log count", nlog, 5);
    chk("R10 entry0", logv[0], {2'd1, 8'h00});
    chk("R10 entry1", logv[1], {2'd2, 8'h11});
    chk("R10 entry2", logv[2], {2'd2, 8'h22});
    chk("R10 entry3", logv[3], {2'd3, 8'h33});
    chk("R10 entry4", logv[4], {2'd1, 8'h30});

    // R8 ready wait, R10 in-flight count
    nand_rb_n = 1'b0;
    mon_clear();
    push(mk(4'h1, 4'hE, 10'h0));
    settle(6);
    push(mk(4'h5, 4'hE, 10'h070));
    settle(30);
    chk("R10 level zero in flight", cmd_status[26:22], 0);
    chk("R8 blocked", n_cle, 0);
    chk("R8 ce held", nand_ce_n, 2);
    nand_rb_n = 1'b1;
    settle(20);
    chk("R8 released", n_cle, 2);

    // R10 level, R11 overflow, R12 clear
    nand_rb_n = 1'b0;
    mon_clear();
    push(mk(4'h1, 4'hE, 10'h0));
    settle(6);
    for (int i = 0; i < 3; i++) push(mk(4'h5, 4'hE, 10'(i)));
    settle(4);
    chk("R10 level", cmd_status[26:22], 2);
    chk("R11 no ovf yet", q_ovf, 0);
    for (int i = 0; i < DEPTH; i++) push(mk(4'h5, 4'hE, 10'(i)));
    settle(4);
    chk("R11 level full", cmd_status[26:22], DEPTH);
    chk("R11 ovf set", q_ovf, 1);
    push(32'h8000_0000);
    settle(2);
    chk("R12 level", cmd_status[26:22], 0);
    chk("R12 ovf", q_ovf, 0);
    chk("R12 abort ce", nand_ce_n, 3);
    chk("R12 cfg kept", cfg_rdata, 1);
    nand_rb_n = 1'b1;
    settle(40);
    chk("R12 nothing ran", n_cle, 0);
    push(mk(4'h5, 4'hE, 10'h044));
    settle(20);
    chk("R12 runs after clear", n_cle, 2);
    chk("R12 byte after clear", last_dq, 8'h44);

    finish_run();
  end
endmodule